// File: doc/BRIEF.md
# Masked Boolean Trigger Evaluator

This block watches a stream of sampled input words, one word per accepted sample, and raises a single-cycle trigger pulse once a programmed condition is met. The condition is built from three input masks. Each mask picks any subset of the input bits and reduces them with one operator. The main condition takes one mask, or two masks joined by a two-input Boolean function. A modifier is then applied to the result: it passes the value through, inverts it, or turns it into a rising, falling or any-edge event.

An optional precondition is built from the masks the main condition leaves free. When it is enabled, the main condition only counts once the precondition has been seen at least once since the block was armed. A length qualifier can also require the gated condition to stay high for fewer than, more than, or between programmed numbers of prescaled ticks. In that case the level's duration is judged on the sample where it drops.

Samples arrive over a valid/ready stream. The block never applies back-pressure: ready is always high, and a sample is consumed on every clock edge where valid is high. The configuration inputs are meant to be held steady while the block is armed. Pulsing `arm` restarts the evaluation.

Top module: `trig_eval`

## Requirements
- R1: Mask i takes its select bits from `cfg_mask_sel[i*N_IN +: N_IN]` and its operator from `cfg_mask_op[2*i +: 2]`. The operator codes are 0 AND, 1 OR, 2 NAND and 3 NOR, applied over the selected bits. An empty selection reduces to 1 under AND and to 0 under OR.
- R2: The joining function codes are 0 AND, 1 NAND, 2 OR, 3 NOR, 4 XOR and 5 XNOR. Codes 6 and 7 act as AND.
- R3: The modifier codes are 0 none, 1 inversion, 2 rising edge, 3 falling edge and 4 any edge. Codes 5 to 7 act as none. An edge compares the current combined value with the one from the previous accepted sample. No edge is reported on the first accepted sample after arm or reset.
- R4: With `cfg_pre_en` high, the main condition counts only when the precondition matched on an earlier accepted sample since the last arm. A match in the same sample does not count. Once seen, the precondition stays seen until the next arm.
- R5: With `cfg_cond_two` low, the condition is mask 0 and the precondition is mask 1 joined with mask 2 by `cfg_pre_fn`. With `cfg_cond_two` high, the condition is mask 0 joined with mask 1 by `cfg_cond_fn`, and the precondition is mask 2 alone.
- R6: The length mode codes are 0 off, 1 lower than, 2 higher than and 3 within. In mode 0 the gated condition fires directly. In modes 1 to 3 a high run of L accepted samples counts as floor(L/(`cfg_presc`+1)) ticks, saturating at the counter maximum. The run is judged on the first accepted sample where it is low, against: ticks < `cfg_len_a`, ticks > `cfg_len_a`, or `cfg_len_a` <= ticks <= `cfg_len_b`. The block never fires while the run is still high.
- R7: `trig` is high for exactly one cycle, in the cycle after the accepted sample that satisfied the condition. It fires at most once per arm.
- R8: A high `arm` at a clock edge clears the precondition flag, the edge history, the length counter and the fired state. Any sample offered in that cycle is discarded.
- R9: `s_ready` is always high. A cycle with `s_valid` low changes no state and cannot cause a trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| arm | input | 1 | Restart evaluation (clears all progress) |
| s_valid | input | 1 | Sample valid |
| s_ready | output | 1 | Sample ready, always high |
| s_data | input | N_IN | Sampled input word |
| cfg_mask_sel | input | 3*N_IN | Bit selection of the three masks |
| cfg_mask_op | input | 6 | Reduction operator per mask |
| cfg_cond_two | input | 1 | Condition uses two masks |
| cfg_cond_fn | input | 3 | Joining function of the condition |
| cfg_cond_mod | input | 3 | Modifier of the condition |
| cfg_pre_en | input | 1 | Precondition enable |
| cfg_pre_fn | input | 3 | Joining function of the precondition |
| cfg_pre_mod | input | 3 | Modifier of the precondition |
| cfg_len_mode | input | 2 | Length qualifier mode |
| cfg_len_a | input | CNT_W | Lower or single tick limit |
| cfg_len_b | input | CNT_W | Upper tick limit (within mode) |
| cfg_presc | input | PRE_W | Samples per tick minus one |
| trig | output | 1 | One-cycle trigger pulse |

## Verification
Several properties are checked on every cycle by assertions. The trigger is a lone single-cycle pulse that follows an accepted sample. It never repeats before a re-arm, and an arm leaves no trigger and no seen precondition behind. A firing with the precondition enabled always has the precondition already seen. An edge event never appears without a previous sample, a length-qualified fire never comes while the run is still high, and the tick count saturates. The actual truth values of each mask operator, joining function and modifier, the same-sample exclusion of the precondition, and the tick boundaries with a prescaler can only be shown by the bench's directed scenarios, which compare the pulse against values derived from the requirements.

// File: rtl/trg_pkg.sv
package trg_pkg;
  localparam int MASKS = 3;

  localparam logic [1:0] RED_AND  = 2'd0;
  localparam logic [1:0] RED_OR   = 2'd1;
  localparam logic [1:0] RED_NAND = 2'd2;
  localparam logic [1:0] RED_NOR  = 2'd3;

  localparam logic [2:0] FN_AND  = 3'd0;
  localparam logic [2:0] FN_NAND = 3'd1;
  localparam logic [2:0] FN_OR   = 3'd2;
  localparam logic [2:0] FN_NOR  = 3'd3;
  localparam logic [2:0] FN_XOR  = 3'd4;
  localparam logic [2:0] FN_XNOR = 3'd5;

  localparam logic [2:0] MOD_NONE = 3'd0;
  localparam logic [2:0] MOD_INV  = 3'd1;
  localparam logic [2:0] MOD_RISE = 3'd2;
  localparam logic [2:0] MOD_FALL = 3'd3;
  localparam logic [2:0] MOD_ANY  = 3'd4;

  localparam logic [1:0] LEN_OFF    = 2'd0;
  localparam logic [1:0] LEN_LT     = 2'd1;
  localparam logic [1:0] LEN_GT     = 2'd2;
  localparam logic [1:0] LEN_WITHIN = 2'd3;
endpackage

// File: rtl/trg_mask.sv
module trg_mask #(
  parameter int N_IN = 16
) (
  input  logic [N_IN-1:0] data,
  input  logic [N_IN-1:0] sel,
  input  logic [1:0]      op,
  output logic            hit
);
  import trg_pkg::*;

  logic all_set;
  logic any_set;

  // R1: unselected bits are neutral for each reduction
  assign all_set = &(data | ~sel);
  assign any_set = |(data & sel);

  always_comb begin
    case (op)
      RED_AND:  hit = all_set;
      RED_OR:   hit = any_set;
      RED_NAND: hit = ~all_set;
      default:  hit = ~any_set;
    endcase
  end
endmodule

// File: rtl/trg_combine.sv
module trg_combine (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       arm,
  input  logic       adv,
  input  logic       a,
  input  logic       b,
  input  logic       use_b,
  input  logic [2:0] fn,
  input  logic [2:0] mod,
  output logic       hit
);
  import trg_pkg::*;

  logic joined;
  logic raw;
  logic prev_q;
  logic hist_q;

  // R2: two-input joining function
  always_comb begin
    case (fn)
      FN_NAND: joined = ~(a & b);
      FN_OR:   joined = a | b;
      FN_NOR:  joined = ~(a | b);
      FN_XOR:  joined = a ^ b;
      FN_XNOR: joined = ~(a ^ b);
      default: joined = a & b;
    endcase
  end

  assign raw = use_b ? joined : a;

  // R3: history of the combined value across accepted samples
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      hist_q <= 1'b0;
    end else if (arm) begin
      prev_q <= 1'b0;
      hist_q <= 1'b0;
    end else if (adv) begin
      prev_q <= raw;
      hist_q <= 1'b1;
    end
  end

  always_comb begin
    case (mod)
      MOD_INV:  hit = ~raw;
      MOD_RISE: hit = hist_q & raw & ~prev_q;
      MOD_FALL: hit = hist_q & ~raw & prev_q;
      MOD_ANY:  hit = hist_q & (raw ^ prev_q);
      default:  hit = raw;
    endcase
  end

  // R3: an edge event needs a previous sample since arm
  a_r3_edge_needs_history: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && (mod == MOD_RISE || mod == MOD_FALL || mod == MOD_ANY)) |-> hist_q);

  // R8: arm drops the history
  a_r8_arm_clears_history: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> !hist_q);
endmodule

// File: rtl/trg_len.sv
module trg_len #(
  parameter int CNT_W = 16,
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm,
  input  logic             adv,
  input  logic             level,
  input  logic [1:0]       mode,
  input  logic [CNT_W-1:0] lim_a,
  input  logic [CNT_W-1:0] lim_b,
  input  logic [PRE_W-1:0] presc,
  output logic             fire
);
  import trg_pkg::*;

  localparam logic [CNT_W-1:0] LEN_MAX = '1;

  logic             lvl_q;
  logic [PRE_W-1:0] sub_q;
  logic [CNT_W-1:0] len_q;
  logic             run_start;
  logic             run_end;
  logic [PRE_W-1:0] base_sub;
  logic [CNT_W-1:0] base_len;
  logic             tick;
  logic [PRE_W-1:0] nxt_sub;
  logic [CNT_W-1:0] nxt_len;
  logic             pass;

  assign run_start = level & ~lvl_q;
  assign run_end   = ~level & lvl_q;
  assign base_sub  = run_start ? '0 : sub_q;
  assign base_len  = run_start ? '0 : len_q;
  assign tick      = (base_sub >= presc);
  assign nxt_sub   = tick ? '0 : base_sub + 1'b1;
  assign nxt_len   = (tick && base_len != LEN_MAX) ? base_len + 1'b1 : base_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= 1'b0;
      sub_q <= '0;
      len_q <= '0;
    end else if (arm) begin
      lvl_q <= 1'b0;
      sub_q <= '0;
      len_q <= '0;
    end else if (adv) begin
      lvl_q <= level;
      if (level) begin
        sub_q <= nxt_sub;
        len_q <= nxt_len;
      end
    end
  end

  // R6: comparison of the finished run
  always_comb begin
    case (mode)
      LEN_LT:     pass = (len_q < lim_a);
      LEN_GT:     pass = (len_q > lim_a);
      LEN_WITHIN: pass = (len_q >= lim_a) && (len_q <= lim_b);
      default:    pass = 1'b1;
    endcase
  end

  assign fire = (mode == LEN_OFF) ? level : (run_end & pass);

  // R6: a qualified fire only happens once the run is over
  a_r6_no_fire_in_run: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && mode != LEN_OFF) |-> !level);

  // R6: the tick count saturates instead of wrapping
  a_r6_len_saturates: assert property (@(posedge clk) disable iff (!rst_n)
    (len_q == LEN_MAX && adv && !arm && level && lvl_q) |=> (len_q == LEN_MAX));
endmodule

// File: rtl/trig_eval.sv
module trig_eval #(
  parameter int N_IN  = 16,
  parameter int CNT_W = 16,
  parameter int PRE_W = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          arm,
  input  logic                          s_valid,
  output logic                          s_ready,
  input  logic [N_IN-1:0]               s_data,
  input  logic [trg_pkg::MASKS*N_IN-1:0] cfg_mask_sel,
  input  logic [2*trg_pkg::MASKS-1:0]   cfg_mask_op,
  input  logic                          cfg_cond_two,
  input  logic [2:0]                    cfg_cond_fn,
  input  logic [2:0]                    cfg_cond_mod,
  input  logic                          cfg_pre_en,
  input  logic [2:0]                    cfg_pre_fn,
  input  logic [2:0]                    cfg_pre_mod,
  input  logic [1:0]                    cfg_len_mode,
  input  logic [CNT_W-1:0]              cfg_len_a,
  input  logic [CNT_W-1:0]              cfg_len_b,
  input  logic [PRE_W-1:0]              cfg_presc,
  output logic                          trig
);
  import trg_pkg::*;

  logic [MASKS-1:0] m_hit;
  logic             adv;
  logic             cond_hit;
  logic             pre_hit;
  logic             pre_a;
  logic             pre_seen_q;
  logic             gated;
  logic             len_fire;
  logic             fire_now;
  logic             done_q;
  logic             trig_q;

  // R9: no back-pressure; arm discards the sample offered with it (R8)
  assign s_ready = 1'b1;
  assign adv     = s_valid & ~arm;

  for (genvar i = 0; i < MASKS; i++) begin : g_mask
    trg_mask #(.N_IN(N_IN)) u_mask (
      .data (s_data),
      .sel  (cfg_mask_sel[i*N_IN +: N_IN]),
      .op   (cfg_mask_op[2*i +: 2]),
      .hit  (m_hit[i])
    );
  end

  // R5: mask sharing between condition and precondition
  assign pre_a = cfg_cond_two ? m_hit[2] : m_hit[1];

  trg_combine u_cond (
    .clk   (clk),
    .rst_n (rst_n),
    .arm   (arm),
    .adv   (adv),
    .a     (m_hit[0]),
    .b     (m_hit[1]),
    .use_b (cfg_cond_two),
    .fn    (cfg_cond_fn),
    .mod   (cfg_cond_mod),
    .hit   (cond_hit)
  );

  trg_combine u_pre (
    .clk   (clk),
    .rst_n (rst_n),
    .arm   (arm),
    .adv   (adv),
    .a     (pre_a),
    .b     (m_hit[2]),
    .use_b (~cfg_cond_two),
    .fn    (cfg_pre_fn),
    .mod   (cfg_pre_mod),
    .hit   (pre_hit)
  );

  // R4: sticky precondition flag, registered so a same-sample match waits
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                pre_seen_q <= 1'b0;
    else if (arm)              pre_seen_q <= 1'b0;
    else if (adv && pre_hit)   pre_seen_q <= 1'b1;
  end

  assign gated = cond_hit & (~cfg_pre_en | pre_seen_q);

  trg_len #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_len (
    .clk   (clk),
    .rst_n (rst_n),
    .arm   (arm),
    .adv   (adv),
    .level (gated),
    .mode  (cfg_len_mode),
    .lim_a (cfg_len_a),
    .lim_b (cfg_len_b),
    .presc (cfg_presc),
    .fire  (len_fire)
  );

  // R7: registered single pulse, once per arm
  assign fire_now = adv & len_fire & ~done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_q <= 1'b0;
      done_q <= 1'b0;
    end else if (arm) begin
      trig_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      trig_q <= fire_now;
      if (fire_now) done_q <= 1'b1;
    end
  end

  assign trig = trig_q;

  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> !trig);

  a_r7_once_per_arm: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !arm) |=> !trig);

  a_r4_pre_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_now && cfg_pre_en) |-> pre_seen_q);

  a_r8_arm_clears: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> (!trig && !pre_seen_q));

  a_r9_trig_after_sample: assert property (@(posedge clk) disable iff (!rst_n)
    trig |-> $past(s_valid && !arm));
endmodule

// File: tb/test_trig_eval.sv
module test_trig_eval;
  localparam int N_IN  = 16;
  localparam int CNT_W = 16;
  localparam int PRE_W = 8;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic                arm = 1'b0;
  logic                s_valid = 1'b0;
  logic                s_ready;
  logic [N_IN-1:0]     s_data = '0;
  logic [3*N_IN-1:0]   cfg_mask_sel = '0;
  logic [5:0]          cfg_mask_op = '0;
  logic                cfg_cond_two = 1'b0;
  logic [2:0]          cfg_cond_fn = '0;
  logic [2:0]          cfg_cond_mod = '0;
  logic                cfg_pre_en = 1'b0;
  logic [2:0]          cfg_pre_fn = '0;
  logic [2:0]          cfg_pre_mod = '0;
  logic [1:0]          cfg_len_mode = '0;
  logic [CNT_W-1:0]    cfg_len_a = '0;
  logic [CNT_W-1:0]    cfg_len_b = '0;
  logic [PRE_W-1:0]    cfg_presc = '0;
  logic                trig;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  trig_eval #(.N_IN(N_IN), .CNT_W(CNT_W), .PRE_W(PRE_W)) i_trig_eval (
    .clk(clk), .rst_n(rst_n), .arm(arm), .s_valid(s_valid), .s_ready(s_ready),
    .s_data(s_data), .cfg_mask_sel(cfg_mask_sel), .cfg_mask_op(cfg_mask_op),
    .cfg_cond_two(cfg_cond_two), .cfg_cond_fn(cfg_cond_fn), .cfg_cond_mod(cfg_cond_mod),
    .cfg_pre_en(cfg_pre_en), .cfg_pre_fn(cfg_pre_fn), .cfg_pre_mod(cfg_pre_mod),
    .cfg_len_mode(cfg_len_mode), .cfg_len_a(cfg_len_a), .cfg_len_b(cfg_len_b),
    .cfg_presc(cfg_presc), .trig(trig)
  );

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: trig actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic do_arm();
    @(negedge clk);
    arm = 1'b1;
    @(negedge clk);
    arm = 1'b0;
  endtask

  // one accepted sample; returns trig in the cycle after it
  task automatic send(input logic [N_IN-1:0] d, output logic t);
    @(negedge clk);
    s_valid = 1'b1;
    s_data  = d;
    @(posedge clk);
    #1;
    t = trig;
    @(negedge clk);
    s_valid = 1'b0;
  endtask

  task automatic expect_on(input string req, input logic [N_IN-1:0] d, input logic exp);
    logic t;
    send(d, t);
    chk(req, t, exp);
  endtask

  task automatic base_cfg();
    cfg_mask_sel = '0; cfg_mask_op = '0; cfg_cond_two = 1'b0;
    cfg_cond_fn = 3'd0; cfg_cond_mod = 3'd0; cfg_pre_en = 1'b0;
    cfg_pre_fn = 3'd0; cfg_pre_mod = 3'd0; cfg_len_mode = 2'd0;
    cfg_len_a = '0; cfg_len_b = '0; cfg_presc = '0;
  endtask

  task automatic t_reset();
    chk("R7 reset", trig, 1'b0);
    chk("R9 ready", s_ready, 1'b1);
  endtask

  task automatic t_masks();
    base_cfg();
    cfg_mask_sel[15:0] = 16'h0003; cfg_mask_op[1:0] = 2'd0; // AND
    do_arm();
    expect_on("R1 and partial", 16'h0001, 1'b0);
    expect_on("R1 and full", 16'h0003, 1'b1);
    expect_on("R7 once per arm", 16'h0003, 1'b0);
    cfg_mask_sel[15:0] = 16'h00F0; cfg_mask_op[1:0] = 2'd3; // NOR
    do_arm();
    expect_on("R1 nor one set", 16'h0010, 1'b0);
    expect_on("R1 nor none set", 16'h0000, 1'b1);
    cfg_mask_sel[15:0] = 16'h0003; cfg_mask_op[1:0] = 2'd2; // NAND
    do_arm();
    expect_on("R1 nand all", 16'h0003, 1'b0);
    expect_on("R1 nand some", 16'h0002, 1'b1);
    cfg_mask_sel[15:0] = 16'h0000; cfg_mask_op[1:0] = 2'd0; // empty AND
    do_arm();
    expect_on("R1 empty and", 16'h0000, 1'b1);
  endtask

  task automatic t_functions();
    base_cfg();
    cfg_cond_two = 1'b1;
    cfg_mask_sel[15:0] = 16'h0001; cfg_mask_op[1:0] = 2'd0;
    cfg_mask_sel[31:16] = 16'h0002; cfg_mask_op[3:2] = 2'd1;
    cfg_cond_fn = 3'd4; do_arm();
    expect_on("R2 xor 11", 16'h0003, 1'b0);
    expect_on("R2 xor 01", 16'h0002, 1'b1);
    cfg_cond_fn = 3'd5; do_arm();
    expect_on("R2 xnor 10", 16'h0001, 1'b0);
    expect_on("R2 xnor 00", 16'h0000, 1'b1);
    cfg_cond_fn = 3'd1; do_arm();
    expect_on("R2 nand 11", 16'h0003, 1'b0);
    expect_on("R2 nand 10", 16'h0001, 1'b1);
    cfg_cond_fn = 3'd3; do_arm();
    expect_on("R2 nor 10", 16'h0001, 1'b0);
    expect_on("R2 nor 00", 16'h0000, 1'b1);
  endtask

  task automatic t_modifiers();
    base_cfg();
    cfg_mask_sel[15:0] = 16'h0001; cfg_mask_op[1:0] = 2'd1;
    cfg_cond_mod = 3'd2; do_arm();
    expect_on("R3 rise first sample", 16'h0001, 1'b0);
    expect_on("R3 rise low", 16'h0000, 1'b0);
    expect_on("R3 rise edge", 16'h0001, 1'b1);
    cfg_cond_mod = 3'd3; do_arm();
    expect_on("R3 fall low", 16'h0000, 1'b0);
    expect_on("R3 fall high", 16'h0001, 1'b0);
    expect_on("R3 fall edge", 16'h0000, 1'b1);
    cfg_cond_mod = 3'd1; do_arm();
    expect_on("R3 inv high", 16'h0001, 1'b0);
    expect_on("R3 inv low", 16'h0000, 1'b1);
    cfg_cond_mod = 3'd4; do_arm();
    expect_on("R3 any first", 16'h0001, 1'b0);
    expect_on("R3 any steady", 16'h0001, 1'b0);
    expect_on("R3 any edge", 16'h0000, 1'b1);
  endtask

  task automatic t_precondition();
    base_cfg();
    cfg_pre_en = 1'b1;
    cfg_mask_sel[15:0] = 16'h0001; cfg_mask_op[1:0] = 2'd1;
    cfg_mask_sel[31:16] = 16'h0002; cfg_mask_op[3:2] = 2'd1;
    cfg_mask_sel[47:32] = 16'h0000; cfg_mask_op[5:4] = 2'd0;
    cfg_pre_fn = 3'd0;
    do_arm();
    expect_on("R4 no pre yet", 16'h0001, 1'b0);
    expect_on("R4 same sample", 16'h0003, 1'b0);
    expect_on("R4 after pre", 16'h0001, 1'b1);
    // R5: condition is m0 AND m1, precondition is m2 alone
    cfg_cond_two = 1'b1; cfg_cond_fn = 3'd0;
    cfg_mask_sel[47:32] = 16'h0004; cfg_mask_op[5:4] = 2'd1;
    do_arm();
    expect_on("R5 cond before pre", 16'h0003, 1'b0);
    expect_on("R5 pre from mask2", 16'h0004, 1'b0);
    expect_on("R5 cond after pre", 16'h0003, 1'b1);
  endtask

  task automatic t_arm();
    base_cfg();
    cfg_pre_en = 1'b1;
    cfg_mask_sel[15:0] = 16'h0001; cfg_mask_op[1:0] = 2'd1;
    cfg_mask_sel[31:16] = 16'h0002; cfg_mask_op[3:2] = 2'd1;
    do_arm();
    expect_on("R8 pre only", 16'h0002, 1'b0);
    do_arm();
    expect_on("R8 pre cleared", 16'h0001, 1'b0);
    // R8: sample presented together with arm is discarded
    do_arm();
    @(negedge clk);
    arm = 1'b1; s_valid = 1'b1; s_data = 16'h0002;
    @(negedge clk);
    arm = 1'b0; s_valid = 1'b0;
    expect_on("R8 arm sample dropped", 16'h0001, 1'b0);
  endtask

  task automatic t_idle();
    base_cfg();
    cfg_mask_sel[15:0] = 16'h0001; cfg_mask_op[1:0] = 2'd1;
    cfg_cond_mod = 3'd2;
    do_arm();
    expect_on("R9 first low", 16'h0000, 1'b0);
    @(negedge clk);
    s_valid = 1'b0; s_data = 16'h0001;
    @(posedge clk); #1;
    chk("R9 invalid ignored", trig, 1'b0);
    @(negedge clk);
    s_data = 16'h0000;
    // history still holds the low value, so a rise is seen now
    expect_on("R9 history kept", 16'h0001, 1'b1);
  endtask

  task automatic run_len(input string req, input int n, input logic exp);
    logic t;
    do_arm();
    for (int k = 0; k < n; k++) begin
      send(16'h0001, t);
      chk("R6 no fire while high", t, 1'b0);
    end
    send(16'h0000, t);
    chk(req, t, exp);
  endtask

  task automatic t_length();
    base_cfg();
    cfg_mask_sel[15:0] = 16'h0001; cfg_mask_op[1:0] = 2'd1;
    cfg_len_mode = 2'd2; cfg_len_a = 16'd3;
    run_len("R6 gt long", 5, 1'b1);
    run_len("R6 gt short", 2, 1'b0);
    run_len("R6 gt equal", 3, 1'b0);
    cfg_len_mode = 2'd1;
    run_len("R6 lt short", 2, 1'b1);
    run_len("R6 lt equal", 3, 1'b0);
    cfg_len_mode = 2'd3; cfg_len_a = 16'd2; cfg_len_b = 16'd4;
    run_len("R6 within above", 5, 1'b0);
    run_len("R6 within inside", 3, 1'b1);
    run_len("R6 within low edge", 2, 1'b1);
    run_len("R6 within below", 1, 1'b0);
    cfg_len_mode = 2'd2; cfg_len_a = 16'd2; cfg_presc = 8'd1;
    run_len("R6 presc 5 samples", 5, 1'b0);
    run_len("R6 presc 6 samples", 6, 1'b1);
  endtask

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not finish, actual running expected done");
    report();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_masks();
    t_functions();
    t_modifiers();
    t_precondition();
    t_arm();
    t_idle();
    t_length();
    repeat (3) @(negedge clk);
    report();
  end
endmodule